// File: doc/BRIEF.md
# Variable Page Size TLB

This block is a fully associative translation buffer that turns 32-bit virtual addresses into 32-bit physical addresses. Each slot maps two adjacent virtual pages, one even and one odd, onto two independent physical frames. Every slot has its own page size, chosen by a three-bit size code. The sizes run from 4 KB to 16 MB and grow fourfold at each step.

The lookup port is combinational. A virtual address, an address-space identifier and a store qualifier go in. In the same cycle a physical address comes out, with exactly one of four outcome flags and a separate multiple-match warning. The results are derived from the table contents stored at the previous clock edge. Management software fills and inspects the slots through an indexed write port, which is registered, and an indexed read port, which is combinational.

Top module: `vps_tlb`

## Requirements
- R1: After reset every field of every slot reads back as zero through the read port.
- R2: A write through the indexed port updates the slot at the clock edge. A lookup or read made in the same cycle as the write still sees the old contents. From the next cycle on, both see the new contents.
- R3: A size code s from 0 to 6 gives pages of 4 KB times 4^s. The slot matches when virtual address bits 31 down to 13+2s equal the same bits of {slot VPN, 13'b0}. Size code 7 behaves exactly like 6.
- R4: Virtual address bit 12+2s selects the frame: 0 selects the even frame and 1 selects the odd frame. The physical address is {frame, 12'b0} with its low 12+2s bits replaced by the same bits of the virtual address.
- R5: A slot matches only if its stored identifier equals the lookup identifier, unless the slot's global bit is set.
- R6: Exactly one of hit, miss, invalid and modify is high at all times. The outcome is:
  - miss when no slot matches;
  - invalid when the selected half has valid=0;
  - modify when the selected half is valid, dirty=0 and the lookup is a store;
  - hit otherwise.
- R7: When several slots match, the lowest-numbered one supplies the result and the multi flag is high. With zero or one match the multi flag is low.
- R8: On a miss the physical address output is zero.
- R9: The read port returns the slot chosen by the read index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_store | input | 1 | Lookup is a store |
| lk_pa | output | 32 | Translated physical address |
| lk_hit | output | 1 | Translation usable |
| lk_miss | output | 1 | No slot matched |
| lk_invalid | output | 1 | Matched half not valid |
| lk_modify | output | 1 | Store to a clean half |
| lk_multi | output | 1 | More than one slot matched |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Slot to write |
| wr_vpn | input | 19 | Virtual page-pair number (VA bits 31:13) |
| wr_size | input | 3 | Page size code |
| wr_asid | input | 8 | Slot identifier |
| wr_global | input | 1 | Ignore identifier on match |
| wr_pfn_even | input | 20 | Even frame number |
| wr_v_even | input | 1 | Even half valid |
| wr_d_even | input | 1 | Even half writable |
| wr_pfn_odd | input | 20 | Odd frame number |
| wr_v_odd | input | 1 | Odd half valid |
| wr_d_odd | input | 1 | Odd half writable |
| rd_idx | input | 5 | Slot to read |
| rd_vpn | output | 19 | Read-back page-pair number |
| rd_size | output | 3 | Read-back size code |
| rd_asid | output | 8 | Read-back identifier |
| rd_global | output | 1 | Read-back global bit |
| rd_pfn_even | output | 20 | Read-back even frame |
| rd_v_even | output | 1 | Read-back even valid |
| rd_d_even | output | 1 | Read-back even dirty |
| rd_pfn_odd | output | 20 | Read-back odd frame |
| rd_v_odd | output | 1 | Read-back odd valid |
| rd_d_odd | output | 1 | Read-back odd dirty |

## Verification
The hardest case to reach is two slots of different sizes, or of different identifier and global settings, that cover the same address. Only the lowest index may win, and its own size must decide the half select and the offset. Random stimulus draws page numbers from a narrow pool and derives lookup addresses from slots already written. Overlaps across sizes therefore happen often. Directed cases add an exact duplicate, the clamped size code, and a lookup made during the write cycle.

// File: rtl/vps_tlb.sv
module vps_tlb #(
  parameter int ENTRIES  = 32,
  parameter int ASID_W   = 8,
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 3,
  parameter int MAX_SIZE = 6,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int PFN_W   = ADDR_W - 12,
  localparam int VPN_W   = ADDR_W - 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_store,
  output logic [ADDR_W-1:0] lk_pa,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_invalid,
  output logic              lk_modify,
  output logic              lk_multi,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PFN_W-1:0]  wr_pfn_even,
  input  logic              wr_v_even,
  input  logic              wr_d_even,
  input  logic [PFN_W-1:0]  wr_pfn_odd,
  input  logic              wr_v_odd,
  input  logic              wr_d_odd,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [VPN_W-1:0]  rd_vpn,
  output logic [SIZE_W-1:0] rd_size,
  output logic [ASID_W-1:0] rd_asid,
  output logic              rd_global,
  output logic [PFN_W-1:0]  rd_pfn_even,
  output logic              rd_v_even,
  output logic              rd_d_even,
  output logic [PFN_W-1:0]  rd_pfn_odd,
  output logic              rd_v_odd,
  output logic              rd_d_odd
);

  logic [VPN_W-1:0]  vpn_q  [ENTRIES];
  logic [SIZE_W-1:0] size_q [ENTRIES];
  logic [ASID_W-1:0] asid_q [ENTRIES];
  logic              glb_q  [ENTRIES];
  logic [PFN_W-1:0]  pfe_q  [ENTRIES];
  logic [PFN_W-1:0]  pfo_q  [ENTRIES];
  logic [1:0]        v_q    [ENTRIES];
  logic [1:0]        d_q    [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]  <= '0;
        size_q[i] <= '0;
        asid_q[i] <= '0;
        glb_q[i]  <= 1'b0;
        pfe_q[i]  <= '0;
        pfo_q[i]  <= '0;
        v_q[i]    <= '0;
        d_q[i]    <= '0;
      end
    end else if (wr_en) begin
      vpn_q[wr_idx]  <= wr_vpn;
      size_q[wr_idx] <= wr_size;
      asid_q[wr_idx] <= wr_asid;
      glb_q[wr_idx]  <= wr_global;
      pfe_q[wr_idx]  <= wr_pfn_even;
      pfo_q[wr_idx]  <= wr_pfn_odd;
      v_q[wr_idx]    <= {wr_v_odd, wr_v_even};
      d_q[wr_idx]    <= {wr_d_odd, wr_d_even};
    end
  end

  assign rd_vpn      = vpn_q[rd_idx];
  assign rd_size     = size_q[rd_idx];
  assign rd_asid     = asid_q[rd_idx];
  assign rd_global   = glb_q[rd_idx];
  assign rd_pfn_even = pfe_q[rd_idx];
  assign rd_pfn_odd  = pfo_q[rd_idx];
  assign rd_v_even   = v_q[rd_idx][0];
  assign rd_v_odd    = v_q[rd_idx][1];
  assign rd_d_even   = d_q[rd_idx][0];
  assign rd_d_odd    = d_q[rd_idx][1];

  logic [ENTRIES-1:0] match;
  logic [SIZE_W-1:0]  sz_c [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic [VPN_W-1:0] cmask;
    assign sz_c[g]  = (size_q[g] > SIZE_W'(MAX_SIZE)) ? SIZE_W'(MAX_SIZE) : size_q[g];
    assign cmask    = {VPN_W{1'b1}} << (2 * sz_c[g]);
    assign match[g] = (((vpn_q[g] ^ lk_va[ADDR_W-1:13]) & cmask) == '0)
                      && (glb_q[g] || (asid_q[g] == lk_asid));
  end

  logic [IDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) sel = IDX_W'(i);
  end

  logic              any;
  logic [5:0]        shamt;
  logic              half;
  logic [ADDR_W-1:0] offmask;
  logic [PFN_W-1:0]  pfn_sel;
  logic              v_sel, d_sel;

  assign any     = |match;
  assign shamt   = 6'd12 + {2'b0, sz_c[sel], 1'b0};
  assign half    = lk_va[shamt];
  assign offmask = ~({ADDR_W{1'b1}} << shamt);
  assign pfn_sel = half ? pfo_q[sel] : pfe_q[sel];
  assign v_sel   = v_q[sel][half];
  assign d_sel   = d_q[sel][half];

  assign lk_pa      = any ? (({pfn_sel, 12'b0} & ~offmask) | (lk_va & offmask)) : '0;
  assign lk_miss    = !any;
  assign lk_invalid = any && !v_sel;
  assign lk_modify  = any && v_sel && lk_store && !d_sel;
  assign lk_hit     = any && v_sel && !(lk_store && !d_sel);
  assign lk_multi   = |(match & (match - ENTRIES'(1)));

  a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({lk_hit, lk_miss, lk_invalid, lk_modify}));

  a_r6_modify_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
    lk_modify |-> lk_store);

  a_r8_miss_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_pa == '0));

  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_miss |-> (lk_pa[11:0] == lk_va[11:0]));

  a_r7_multi_has_match: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> !lk_miss);

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && (rd_idx == $past(wr_idx))) |->
      ((rd_vpn == $past(wr_vpn)) && (rd_pfn_odd == $past(wr_pfn_odd))
       && (rd_size == $past(wr_size))));

endmodule

// File: tb/vps_tlb_tb_top.sv
`timescale 1ns/1ps
module vps_tlb_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_store = 1'b0;
  logic [31:0] lk_pa;
  logic        lk_hit, lk_miss, lk_invalid, lk_modify, lk_multi;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [18:0] wr_vpn = '0;
  logic [2:0]  wr_size = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_global = 1'b0;
  logic [19:0] wr_pfn_even = '0, wr_pfn_odd = '0;
  logic        wr_v_even = 1'b0, wr_d_even = 1'b0, wr_v_odd = 1'b0, wr_d_odd = 1'b0;
  logic [4:0]  rd_idx = '0;
  logic [18:0] rd_vpn;
  logic [2:0]  rd_size;
  logic [7:0]  rd_asid;
  logic        rd_global;
  logic [19:0] rd_pfn_even, rd_pfn_odd;
  logic        rd_v_even, rd_d_even, rd_v_odd, rd_d_odd;

  vps_tlb dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [18:0] m_vpn [32];
  logic [2:0]  m_size [32];
  logic [7:0]  m_asid [32];
  bit          m_g [32];
  logic [19:0] m_pe [32], m_po [32];
  bit          m_ve [32], m_de [32], m_vo [32], m_do [32];

  function automatic void ref_lookup(input logic [31:0] va, input logic [7:0] asid, input bit st,
                                     output logic [31:0] pa, output logic [4:0] fl);
    int cnt = 0;
    int first = -1;
    longint pair, page, base, frame;
    bit h, v, d;
    for (int i = 0; i < 32; i++) begin
      int s = (m_size[i] > 3'd6) ? 6 : int'(m_size[i]);
      pair = 64'd8192 << (2 * s);
      if ((longint'(va) / pair) == ((longint'(m_vpn[i]) * 8192) / pair) &&
          (m_g[i] || m_asid[i] == asid)) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) begin
      pa = '0;
      fl = 5'b00100;
      return;
    end
    begin
      int s = (m_size[first] > 3'd6) ? 6 : int'(m_size[first]);
      page = 64'd4096 << (2 * s);
      h = ((longint'(va) / page) % 2) == 1;
      frame = h ? longint'(m_po[first]) : longint'(m_pe[first]);
      v = h ? m_vo[first] : m_ve[first];
      d = h ? m_do[first] : m_de[first];
      base = ((frame * 4096) / page) * page;
      pa = 32'(base + (longint'(va) % page));
    end
    // fl = {hit, invalid, miss, modify, multi}
    fl[4] = v && !(st && !d);
    fl[3] = !v;
    fl[2] = 1'b0;
    fl[1] = v && st && !d;
    fl[0] = cnt > 1;
  endfunction

  task automatic check_lookup(input logic [31:0] va, input logic [7:0] asid, input bit st,
                              input string tag);
    logic [31:0] epa;
    logic [4:0]  efl, afl;
    lk_va = va; lk_asid = asid; lk_store = st;
    #1;
    ref_lookup(va, asid, st, epa, efl);
    afl = {lk_hit, lk_invalid, lk_miss, lk_modify, lk_multi};
    checks++;
    if (afl !== efl || lk_pa !== epa) begin
      errors++;
      $display("FAIL %s va=%h asid=%0d st=%0d: pa=%h flags=%b expected pa=%h flags=%b",
               tag, va, asid, st, lk_pa, afl, epa, efl);
    end
  endtask

  task automatic check_read(input logic [4:0] idx, input string tag);
    logic [79:0] act, exp;
    rd_idx = idx;
    #1;
    act = {rd_vpn, rd_size, rd_asid, rd_global, rd_pfn_even, rd_v_even, rd_d_even,
           rd_pfn_odd, rd_v_odd, rd_d_odd};
    exp = {m_vpn[idx], m_size[idx], m_asid[idx], m_g[idx], m_pe[idx], m_ve[idx], m_de[idx],
           m_po[idx], m_vo[idx], m_do[idx]};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s slot %0d: read=%h expected=%h", tag, idx, act, exp);
    end
  endtask

  task automatic drive_write(input logic [4:0] idx, input logic [18:0] vpn, input logic [2:0] sz,
                             input logic [7:0] asid, input bit g,
                             input logic [19:0] pe, input bit ve, input bit de,
                             input logic [19:0] po, input bit vo, input bit dd);
    wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_size = sz; wr_asid = asid; wr_global = g;
    wr_pfn_even = pe; wr_v_even = ve; wr_d_even = de;
    wr_pfn_odd = po; wr_v_odd = vo; wr_d_odd = dd;
  endtask

  task automatic commit_write();
    @(posedge clk);
    m_vpn[wr_idx] = wr_vpn; m_size[wr_idx] = wr_size; m_asid[wr_idx] = wr_asid;
    m_g[wr_idx] = wr_global; m_pe[wr_idx] = wr_pfn_even; m_ve[wr_idx] = wr_v_even;
    m_de[wr_idx] = wr_d_even; m_po[wr_idx] = wr_pfn_odd; m_vo[wr_idx] = wr_v_odd;
    m_do[wr_idx] = wr_d_odd;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_slot(input logic [4:0] idx, input logic [18:0] vpn, input logic [2:0] sz,
                            input logic [7:0] asid, input bit g,
                            input logic [19:0] pe, input bit ve, input bit de,
                            input logic [19:0] po, input bit vo, input bit dd);
    drive_write(idx, vpn, sz, asid, g, pe, ve, de, po, vo, dd);
    commit_write();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_71B0));
    for (int i = 0; i < 32; i++) begin
      m_vpn[i] = '0; m_size[i] = '0; m_asid[i] = '0; m_g[i] = 0;
      m_pe[i] = '0; m_po[i] = '0; m_ve[i] = 0; m_de[i] = 0; m_vo[i] = 0; m_do[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset contents
    check_read(5'd0, "R1");
    check_read(5'd17, "R1");
    check_read(5'd31, "R1");
    check_lookup(32'h8000_0000, 8'd0, 0, "R6 miss after reset");

    // R2 lookup during the write cycle sees old contents
    @(negedge clk);
    drive_write(5'd3, 19'h40000, 3'd0, 8'd5, 0, 20'h12345, 1, 1, 20'h54321, 1, 0);
    check_lookup(32'h8000_0123, 8'd5, 0, "R2 same cycle");
    commit_write();
    check_lookup(32'h8000_0123, 8'd5, 0, "R2 next cycle");
    check_lookup(32'h8000_1ABC, 8'd5, 0, "R4 odd half");
    check_lookup(32'h8000_1ABC, 8'd5, 1, "R6 modify on clean odd");
    check_lookup(32'h8000_0ABC, 8'd5, 1, "R6 store to dirty even");
    check_lookup(32'h8000_0ABC, 8'd6, 0, "R5 asid mismatch");
    check_lookup(32'h8000_2000, 8'd5, 0, "R8 outside pair");
    check_read(5'd3, "R9");

    // R3 64 KB pages, global
    write_slot(5'd4, 19'h20000, 3'd2, 8'd1, 1, 20'hAAAA0, 1, 1, 20'hBBBB0, 1, 1);
    check_lookup(32'h4001_2345, 8'd9, 0, "R5 global any asid");
    check_lookup(32'h4000_F00D, 8'd2, 1, "R3 even 64K");
    check_lookup(32'h4002_0000, 8'd1, 0, "R3 beyond pair");

    // R3 size code 7 clamps to 16 MB pages
    write_slot(5'd6, 19'h10000, 3'd7, 8'd3, 0, 20'h11111, 1, 1, 20'hFE000, 1, 1);
    check_lookup(32'h21FF_FFFF, 8'd3, 0, "R3 clamp odd");
    check_lookup(32'h2000_0004, 8'd3, 0, "R3 clamp even");
    check_lookup(32'h2200_0000, 8'd3, 0, "R3 clamp miss");
    check_read(5'd6, "R9");

    // R7 duplicate slots: lowest index wins
    write_slot(5'd10, 19'h30000, 3'd0, 8'd0, 1, 20'h0F0F0, 1, 1, 20'h0, 0, 0);
    check_lookup(32'h6000_0010, 8'd4, 0, "R7 single match");
    write_slot(5'd2, 19'h30000, 3'd0, 8'd0, 1, 20'h0A0A0, 1, 1, 20'h0, 0, 0);
    check_lookup(32'h6000_0010, 8'd4, 0, "R7 lowest index");
    check_lookup(32'h6000_1010, 8'd4, 0, "R6 invalid odd");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      if ($urandom % 3 == 0) begin
        logic [18:0] vpn;
        vpn = 19'((($urandom % 4) + 8) << 15) | 19'($urandom & 32'h7FFF);
        write_slot(5'($urandom), vpn, 3'($urandom), 8'($urandom % 4), ($urandom % 6) == 0,
                   20'($urandom), $urandom % 4 != 0, $urandom % 2 == 0,
                   20'($urandom), $urandom % 4 != 0, $urandom % 2 == 0);
      end
      begin
        logic [31:0] va;
        if ($urandom % 10 < 7) begin
          int k = int'($urandom % 32);
          int s = (m_size[k] > 3'd6) ? 6 : int'(m_size[k]);
          va = {m_vpn[k], 13'b0} ^ ($urandom & ((32'd1 << (13 + 2 * s)) - 1));
        end else begin
          va = $urandom;
        end
        check_lookup(va, 8'($urandom % 4), $urandom % 2 == 0, "random R6 R7");
      end
      if (n % 50 == 0) check_read(5'($urandom), "random R9");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule